// File: doc/BRIEF.md
# Irregularly clocked linear shift register

This block is the linear half of a two-register keystream generator. It holds a 128-bit linear feedback shift register. On each clock it takes one of two update rules, and a single control bit picks which. The control bit is the XOR of one bit of this register and one bit of a companion nonlinear register. The companion register lives outside the block and supplies that bit on an input port. In the plain rule the register shifts toward bit 0, and the bit that leaves at bit 0 is fed back into every stage named in a tap mask. In the folding rule each stage is also XORed with its own value from before the shift. This folding step is multiplication of the register polynomial by x+1.

A load port forces external data into the register, for example while key and initialization vector material is being clocked in. The block gives out its bit 0 XORed with the companion register's bit 0 as one keystream bit per clock. It also gives out its bit 42, which the companion register needs for its own control bit. A keystream-valid flag rises once the surrounding controller reports that setup has finished. The key is 128 bits. The initialization vector may be any length from 0 to 128 bits, and the sequencing of that setup is done outside this block.

Top module: `irreg_lfsr`

## Requirements
- R1: While reset is asserted, and after it is released, the register reads all zeros and `ks_valid_o` is 0 until the first load or step.
- R2: With `load` high, the register takes `load_data` at the next edge, whatever the values of `en`, `mate_ctrl_bit` and the current state.
- R3: With `load` low, `en` high and control bit 0, the new state is next[i] = s[i+1] XOR (TAP[i] AND s[0]), where s[128] is taken as 0.
- R4: With `load` low, `en` high and control bit 1, the new state is the R3 value XORed with s[i] for each stage i.
- R5: The control bit `ctrl_o` equals register bit 85 XOR `mate_ctrl_bit`, which is the companion register's bit 43.
- R6: With `load` low and `en` low, the register holds its value.
- R7: `keystream_o` equals register bit 0 XOR `mate_lsb`, which is the companion register's bit 0.
- R8: `tap42_o` always equals register bit 42.
- R9: `ks_valid_o` is an internal armed flag ANDed with `en`. The flag is set at the edge after a cycle with `init_done` high. It is cleared at the edge after a cycle with `load` high, and `load` takes priority over `init_done`.
- R10: An all-zero register stays all zero under stepping in both modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Step enable |
| load | input | 1 | Load strobe; takes priority over stepping |
| load_data | input | 128 | Data forced into the register on load |
| mate_ctrl_bit | input | 1 | Companion register bit 43 |
| mate_lsb | input | 1 | Companion register bit 0 |
| init_done | input | 1 | Setup finished; arms the valid flag |
| state_o | output | 128 | Current register contents |
| ctrl_o | output | 1 | Control bit chosen for this cycle |
| tap42_o | output | 1 | Register bit 42, sent to the companion register |
| keystream_o | output | 1 | Keystream bit |
| ks_valid_o | output | 1 | Keystream bit is valid |

## Verification
Two kinds of cycle can overlap. A load can land in a cycle where stepping is also enabled and the control bit is 1. And `init_done` can be high in the same cycle as a load. The bench drives both overlaps on purpose. It expects the loaded data to win over the step, and it expects the valid flag to stay cleared. Random walks with random control inputs are compared against an arithmetic model of the two step rules. A run from the all-zero state shows that neither mode can leave zero.

// File: rtl/irl_pkg.sv
package irl_pkg;
  localparam int unsigned IRL_WIDTH = 128;

  typedef enum logic {
    STEP_PLAIN = 1'b0,
    STEP_FOLD  = 1'b1
  } step_mode_e;
endpackage

// File: rtl/irl_rst_sync.sv
module irl_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/irl_ctrl.sv
module irl_ctrl
  import irl_pkg::*;
(
  input  logic       own_bit,
  input  logic       mate_bit,
  output step_mode_e mode
);
  always_comb begin
    mode = (own_bit ^ mate_bit) ? STEP_FOLD : STEP_PLAIN;
  end
endmodule

// File: rtl/irl_next_state.sv
module irl_next_state
  import irl_pkg::*;
#(
  parameter int unsigned          W   = 128,
  parameter logic [W-1:0]         TAP = '0
) (
  input  logic [W-1:0] cur,
  input  step_mode_e   mode,
  output logic [W-1:0] nxt
);
  logic fb;
  logic fold_en;

  assign fb      = cur[0];
  assign fold_en = (mode == STEP_FOLD);

  for (genvar i = 0; i < W; i++) begin : g_stage
    logic upper;
    logic self_term;
    if (i == W - 1) begin : g_top
      assign upper = 1'b0;
    end else begin : g_mid
      assign upper = cur[i+1];
    end
    // per-stage AND gate passes the stage's own value only in fold mode
    assign self_term = fold_en & cur[i];
    if (TAP[i]) begin : g_tapped
      assign nxt[i] = upper ^ fb ^ self_term;
    end else begin : g_plain
      assign nxt[i] = upper ^ self_term;
    end
  end
endmodule

// File: rtl/irl_ks_out.sv
module irl_ks_out (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic load,
  input  logic init_done,
  input  logic own_lsb,
  input  logic mate_lsb,
  output logic keystream,
  output logic ks_valid
);
  logic armed_q;
  logic armed_d;

  always_comb begin
    armed_d = armed_q;
    if (load)           armed_d = 1'b0;
    else if (init_done) armed_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= armed_d;
  end

  assign keystream = own_lsb ^ mate_lsb;
  assign ks_valid  = armed_q & en;
endmodule

// File: rtl/irreg_lfsr.sv
module irreg_lfsr
  import irl_pkg::*;
#(
  parameter int unsigned  W             = IRL_WIDTH,
  parameter logic [W-1:0] TAP           = {1'b1, {(W-33){1'b0}}, 32'h2800_0004},
  parameter int unsigned  CTRL_IDX      = 85,
  parameter int unsigned  MATE_TAP_IDX  = 42
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         mate_ctrl_bit,
  input  logic         mate_lsb,
  input  logic         init_done,
  output logic [W-1:0] state_o,
  output logic         ctrl_o,
  output logic         tap42_o,
  output logic         keystream_o,
  output logic         ks_valid_o
);
  logic         rst_sync_n;
  logic [W-1:0] state_q;
  logic [W-1:0] state_d;
  logic [W-1:0] stepped;
  step_mode_e   mode;

  irl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irl_ctrl u_ctrl (
    .own_bit  (state_q[CTRL_IDX]),
    .mate_bit (mate_ctrl_bit),
    .mode     (mode)
  );

  irl_next_state #(.W(W), .TAP(TAP)) u_next (
    .cur  (state_q),
    .mode (mode),
    .nxt  (stepped)
  );

  irl_ks_out u_ks (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .en        (en),
    .load      (load),
    .init_done (init_done),
    .own_lsb   (state_q[0]),
    .mate_lsb  (mate_lsb),
    .keystream (keystream_o),
    .ks_valid  (ks_valid_o)
  );

  always_comb begin
    state_d = state_q;
    if (load)    state_d = load_data;
    else if (en) state_d = stepped;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) state_q <= '0;
    else             state_q <= state_d;
  end

  assign state_o = state_q;
  assign ctrl_o  = (mode == STEP_FOLD);
  assign tap42_o = state_q[MATE_TAP_IDX];
endmodule

// File: rtl/irl_checker.sv
module irl_checker #(
  parameter int unsigned  W   = 128,
  parameter logic [W-1:0] TAP = '0
) (
  input logic         clk,
  input logic         rst_sync_n,
  input logic         en,
  input logic         load,
  input logic [W-1:0] load_data,
  input logic [W-1:0] state_q,
  input logic         ctrl_o,
  input logic         init_done,
  input logic         ks_valid_o
);
  assert_load_wins_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> state_q == $past(load_data));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && !en) |=> $stable(state_q));

  assert_plain_top_R3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && en && !ctrl_o) |=>
      state_q[W-2] == ($past(state_q[W-1]) ^ (TAP[W-2] & $past(state_q[0]))));

  assert_fold_top_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && en && ctrl_o) |=>
      state_q[W-2] == ($past(state_q[W-1]) ^ (TAP[W-2] & $past(state_q[0]))
                       ^ $past(state_q[W-2])));

  assert_zero_sticks_R10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!load && state_q == '0) |=> state_q == '0);

  assert_load_disarms_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    load |=> !ks_valid_o);

  assert_arm_cause_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (en && $past(en) && $rose(ks_valid_o)) |-> $past(init_done));
endmodule

bind irreg_lfsr irl_checker #(.W(W), .TAP(TAP)) u_irl_checker (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .en         (en),
  .load       (load),
  .load_data  (load_data),
  .state_q    (state_q),
  .ctrl_o     (ctrl_o),
  .init_done  (init_done),
  .ks_valid_o (ks_valid_o)
);

// File: tb/test_irreg_lfsr.sv
module test_irreg_lfsr;
  localparam int unsigned  W    = 128;
  localparam logic [W-1:0] TAPM = {1'b1, {(W-33){1'b0}}, 32'h2800_0004};

  logic         clk = 1'b0;
  logic         rst_n;
  logic         en, load, mate_ctrl_bit, mate_lsb, init_done;
  logic [W-1:0] load_data;
  logic [W-1:0] state_o;
  logic         ctrl_o, tap42_o, keystream_o, ks_valid_o;

  int errors = 0;
  int checks = 0;
  bit done   = 1'b0;

  logic [W-1:0] exp_s   = '0;
  bit           exp_arm = 1'b0;

  always #5 clk = ~clk;

  irreg_lfsr #(.W(W), .TAP(TAPM)) i_irreg_lfsr (
    .clk(clk), .rst_n(rst_n), .en(en), .load(load), .load_data(load_data),
    .mate_ctrl_bit(mate_ctrl_bit), .mate_lsb(mate_lsb), .init_done(init_done),
    .state_o(state_o), .ctrl_o(ctrl_o), .tap42_o(tap42_o),
    .keystream_o(keystream_o), .ks_valid_o(ks_valid_o)
  );

  function automatic logic [W-1:0] model_step(logic [W-1:0] s, bit fold);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) begin
      r[i] = ((i == W-1) ? 1'b0 : s[i+1]) ^ (TAPM[i] & s[0]) ^ (fold & s[i]);
    end
    return r;
  endfunction

  task automatic check(bit ok, string req, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cycle(bit ld, logic [W-1:0] ldd, bit e, bit mc, bit mb, bit id);
    bit           fold;
    logic [W-1:0] nxt;
    string        tag;
    @(negedge clk);
    load = ld; load_data = ldd; en = e; mate_ctrl_bit = mc; mate_lsb = mb; init_done = id;
    #1;
    fold = exp_s[85] ^ mc;
    check(ctrl_o == fold, "R5", W'(ctrl_o), W'(fold));
    check(keystream_o == (exp_s[0] ^ mb), "R7", W'(keystream_o), W'(exp_s[0] ^ mb));
    check(tap42_o == exp_s[42], "R8", W'(tap42_o), W'(exp_s[42]));
    check(ks_valid_o == (exp_arm & e), "R9", W'(ks_valid_o), W'(exp_arm & e));
    if (ld)      begin nxt = ldd; tag = "R2"; end
    else if (e)  begin nxt = model_step(exp_s, fold); tag = fold ? "R4" : "R3"; end
    else         begin nxt = exp_s; tag = "R6"; end
    if (ld) exp_arm = 1'b0; else if (id) exp_arm = 1'b1;
    @(posedge clk); #1;
    check(state_o == nxt, tag, state_o, nxt);
    exp_s = nxt;
  endtask

  function automatic logic [W-1:0] rnd_word();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  initial begin
    rst_n = 1'b0; en = 0; load = 0; load_data = '0;
    mate_ctrl_bit = 0; mate_lsb = 0; init_done = 0;
    repeat (3) @(posedge clk);
    #1;
    check(state_o == '0, "R1", state_o, '0);
    check(ks_valid_o == 1'b0, "R1", W'(ks_valid_o), '0);
    @(negedge clk); rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check(state_o == '0, "R1", state_o, '0);

    // R10: zero state in both modes, all control combinations
    for (int k = 0; k < 16; k++) cycle(0, '0, 1, k[0], k[1], 0);
    check(state_o == '0, "R10", state_o, '0);

    // R2: load wins over a folding step and over disabled stepping
    cycle(1, {W{1'b1}}, 1, 1, 0, 0);
    cycle(1, 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210, 0, 1, 1, 0);

    // sweep all four (own bit 85, mate bit) pairs, both enable levels
    for (int p = 0; p < 8; p++) begin
      logic [W-1:0] seed = rnd_word();
      seed[85] = p[0];
      cycle(1, seed, 0, 0, 0, 0);
      cycle(0, '0, p[2] ? 1'b0 : 1'b1, p[1], p[0], 0);
    end

    // R9: arm, keep, load together with init_done disarms
    cycle(0, '0, 1, 0, 1, 1);
    cycle(0, '0, 1, 1, 0, 0);
    cycle(0, '0, 0, 0, 0, 0);
    cycle(1, rnd_word(), 1, 1, 1, 1);
    cycle(0, '0, 1, 0, 0, 0);
    cycle(0, '0, 1, 0, 0, 1);

    // long random walks against the model
    for (int r = 0; r < 4000; r++) begin
      bit ld = ($urandom_range(0, 63) == 0);
      cycle(ld, rnd_word(), $urandom_range(0, 7) != 0, $urandom_range(0, 1),
            $urandom_range(0, 1), $urandom_range(0, 31) == 0);
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule